// File: doc/BRIEF.md
# Chainable Counter/Timer Pair

Two identical counter/timers of `W` bits (32 by default) sit behind a small register port. Each timer has a configuration word, a limit word and a live count word. A timer counts down from its limit to zero, or up from zero to its limit. On reaching that terminal value it either stops (one-shot) or reloads and carries on (continuous). Each terminal event sets a sticky flag. The flag drives that timer's interrupt line when interrupts are enabled for it.

When both timers have their chain bit set, they form one counter of `2*W` bits. Timer 1 holds the upper word and timer 0 the lower word. Carries and borrows cross the word boundary. The terminal test uses the full double-width count and limit. Switching either timer on or off switches the pair together. Software may overwrite the live count at any moment, and counting resumes from the written value.

Top module: `tmr_pair`

## Requirements
- R1: After reset every readable register of both timers reads zero and both interrupt outputs are low.
- R2: Address bit 2 selects the timer (0 or 1) and bits 1:0 select the word: 0 = configuration, 1 = limit, 2 = live count, 3 = status (bit 0 = flag). Configuration bits are 0 = enable, 1 = one-shot (0 = continuous), 2 = up (0 = down), 3 = chain, 4 = interrupt enable. A read returns the current register content in the same cycle, and a write takes effect at the next clock edge.
- R3: A fresh start happens at the edge where enable goes from 0 to 1. A down-counting timer then loads its limit and an up-counting timer loads zero. While enable is 0 the count holds.
- R4: An enabled down-counting timer decrements by one per cycle, and its terminal value is zero.
- R5: An enabled up-counting timer increments by one per cycle, and its terminal value is its limit.
- R6: In one-shot mode, the edge after the count shows its terminal value clears the enable bit, and the count keeps the terminal value.
- R7: In continuous mode, the edge after the count shows its terminal value reloads the count (limit when counting down, zero when counting up), and counting goes on.
- R8: A write to the live count word replaces the count at the next edge, taking priority over that cycle's step. Counting then continues from the written value.
- R9: A count written while the timer is disabled is replaced by the fresh-start value when the timer is next enabled.
- R10: With both chain bits set, {timer 1 count, timer 0 count} steps as one double-width value in the direction given by timer 0's up bit. Carries and borrows pass between the words. The terminal test compares the whole double-width count with {limit 1, limit 0} or with zero, so a low word of zero alone is not terminal.
- R11: A configuration write whose chain bit is 1 to one timer copies its enable bit into the other timer when the other timer's chain bit is already 1, so the pair starts and stops together.
- R12: Each terminal event sets the timer's sticky flag (both flags in chained mode). Writing 1 to status bit 0 clears the flag; writing 0 leaves it. The interrupt output is the flag ANDed with the interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Timer select (bit 2) and word select (bits 1:0) |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for `reg_addr`, combinational |
| irq | output | 2 | Per-timer interrupt, flag gated by interrupt enable |

## Verification
A wrong count register shows on the live count word one cycle after the faulty edge, because reads are combinational and every enabled cycle moves the count by exactly one. A missed carry or borrow between the chained words shows on the upper word at the single edge where the lower word wraps. A wrong terminal decision shows at the next edge as an enable bit that stays set or clears too early, or as a flag that stays low, and this can be read back at once. A lost enable copy between chained timers shows on the very next read of the peer's configuration word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Configuration word, LSB first: en, oneshot, up, chain, irq_en
  typedef struct packed {
    logic irq_en;
    logic chain;
    logic up;
    logic oneshot;
    logic en;
  } tmr_cfg_t;

  localparam int CFG_W = 5;

  typedef enum logic [1:0] {
    RS_CFG  = 2'd0,
    RS_LIM  = 2'd1,
    RS_CNT  = 2'd2,
    RS_STAT = 2'd3
  } tmr_reg_e;

endpackage

// File: rtl/tmr_step.sv
// Next-count and terminal-detect datapath for both words of the pair.
module tmr_step #(
  parameter int W = 32
) (
  input  logic         chained,
  input  logic         up_lo,
  input  logic         up_hi,
  input  logic [W-1:0] cnt_lo,
  input  logic [W-1:0] cnt_hi,
  input  logic [W-1:0] lim_lo,
  input  logic [W-1:0] lim_hi,
  output logic [W-1:0] nxt_lo,
  output logic [W-1:0] nxt_hi,
  output logic         hit_lo,
  output logic         hit_hi
);
  localparam int DW = 2 * W;

  logic [DW-1:0] cat_cnt;
  logic [DW-1:0] cat_lim;
  logic [DW-1:0] cat_nxt;
  logic          cat_hit;

  always_comb begin
    cat_cnt = {cnt_hi, cnt_lo};
    cat_lim = {lim_hi, lim_lo};
    cat_nxt = up_lo ? (cat_cnt + DW'(1)) : (cat_cnt - DW'(1));
    cat_hit = up_lo ? (cat_cnt == cat_lim) : (cat_cnt == '0);
    if (chained) begin
      nxt_lo = cat_nxt[W-1:0];
      nxt_hi = cat_nxt[DW-1:W];
      hit_lo = cat_hit;
      hit_hi = cat_hit;
    end else begin
      nxt_lo = up_lo ? (cnt_lo + W'(1)) : (cnt_lo - W'(1));
      nxt_hi = up_hi ? (cnt_hi + W'(1)) : (cnt_hi - W'(1));
      hit_lo = up_lo ? (cnt_lo == lim_lo) : (cnt_lo == '0);
      hit_hi = up_hi ? (cnt_hi == lim_hi) : (cnt_hi == '0);
    end
  end

endmodule

// File: rtl/tmr_chan.sv
// State of one timer: configuration, limit, live count and sticky flag.
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_cfg,
  input  logic         wr_lim,
  input  logic         wr_cnt,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  input  logic         sync_we,
  input  logic         sync_en,
  input  logic         hit,
  input  logic         blk,
  input  logic [W-1:0] step_val,
  output tmr_cfg_t     cfg_q,
  output logic [W-1:0] lim_q,
  output logic [W-1:0] cnt_q,
  output logic         flag_q,
  output logic         irq
);
  tmr_cfg_t     cfg_d;
  tmr_cfg_t     wcfg;
  logic [W-1:0] cnt_d;
  logic         flag_d;
  logic         start;
  logic         ev;

  always_comb begin
    wcfg  = tmr_cfg_t'(wdata[CFG_W-1:0]);
    ev    = cfg_q.en & hit & ~blk;
    cfg_d = cfg_q;
    if (ev && cfg_q.oneshot) cfg_d.en = 1'b0;
    if (wr_cfg)       cfg_d    = wcfg;
    else if (sync_we) cfg_d.en = sync_en;
    start = cfg_d.en & ~cfg_q.en;

    cnt_d = cnt_q;
    if (wr_cnt)                   cnt_d = wdata;
    else if (start)               cnt_d = cfg_d.up ? '0 : lim_q;
    else if (ev && !cfg_q.oneshot) cnt_d = cfg_q.up ? '0 : lim_q;
    else if (ev)                  cnt_d = cnt_q;
    else if (cfg_q.en)            cnt_d = step_val;

    flag_d = flag_q;
    if (wr_clr && wdata[0]) flag_d = 1'b0;
    if (ev)                 flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      lim_q  <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      if (wr_lim) lim_q <= wdata;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign irq = flag_q & cfg_q.irq_en;

endmodule

// File: rtl/tmr_pair.sv
// Two counter/timers with a shared register port and optional chaining.
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic [1:0]   irq
);
  localparam int NT = 2;

  tmr_cfg_t     cfg_q  [NT];
  logic [W-1:0] lim_q  [NT];
  logic [W-1:0] cnt_q  [NT];
  logic [W-1:0] nxt    [NT];
  logic         hit    [NT];
  logic         flag_q [NT];
  logic         chained;
  logic         wr_dat_any;
  tmr_cfg_t     wcfg;
  tmr_reg_e     wsel;

  always_comb begin
    chained    = cfg_q[0].chain & cfg_q[1].chain;
    wsel       = tmr_reg_e'(reg_addr[1:0]);
    wr_dat_any = reg_wr & (wsel == RS_CNT);
    wcfg       = tmr_cfg_t'(reg_wdata[CFG_W-1:0]);
  end

  tmr_step #(.W(W)) u_step (
    .chained (chained),
    .up_lo   (cfg_q[0].up),
    .up_hi   (cfg_q[1].up),
    .cnt_lo  (cnt_q[0]),
    .cnt_hi  (cnt_q[1]),
    .lim_lo  (lim_q[0]),
    .lim_hi  (lim_q[1]),
    .nxt_lo  (nxt[0]),
    .nxt_hi  (nxt[1]),
    .hit_lo  (hit[0]),
    .hit_hi  (hit[1])
  );

  for (genvar k = 0; k < NT; k++) begin : g_tmr
    localparam int PEER = NT - 1 - k;
    logic own_sel;
    logic peer_cfg_wr;
    logic sync_we;
    logic blk;

    always_comb begin
      own_sel     = reg_wr & (reg_addr[2] == 1'(k));
      peer_cfg_wr = reg_wr & (reg_addr[2] == 1'(PEER)) & (wsel == RS_CFG);
      sync_we     = peer_cfg_wr & wcfg.chain & cfg_q[k].chain;
      blk         = chained ? wr_dat_any : (own_sel & (wsel == RS_CNT));
    end

    tmr_chan #(.W(W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cfg   (own_sel & (wsel == RS_CFG)),
      .wr_lim   (own_sel & (wsel == RS_LIM)),
      .wr_cnt   (own_sel & (wsel == RS_CNT)),
      .wr_clr   (own_sel & (wsel == RS_STAT)),
      .wdata    (reg_wdata),
      .sync_we  (sync_we),
      .sync_en  (wcfg.en),
      .hit      (hit[k]),
      .blk      (blk),
      .step_val (nxt[k]),
      .cfg_q    (cfg_q[k]),
      .lim_q    (lim_q[k]),
      .cnt_q    (cnt_q[k]),
      .flag_q   (flag_q[k]),
      .irq      (irq[k])
    );
  end

  always_comb begin
    unique case (tmr_reg_e'(reg_addr[1:0]))
      RS_CFG:  reg_rdata = {{(W-CFG_W){1'b0}}, cfg_q[reg_addr[2]]};
      RS_LIM:  reg_rdata = lim_q[reg_addr[2]];
      RS_CNT:  reg_rdata = cnt_q[reg_addr[2]];
      default: reg_rdata = {{(W-1){1'b0}}, flag_q[reg_addr[2]]};
    endcase
  end

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr,
  input logic [2:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input tmr_cfg_t     cfg0,
  input tmr_cfg_t     cfg1,
  input logic [W-1:0] cnt0,
  input logic         flag0
);

  AST_CHAIN_EN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg0.chain && cfg1.chain) |-> (cfg0.en == cfg1.en))
    else $error("chained enables differ"); // R11

  AST_DATA_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2) |=> (cnt0 == $past(reg_wdata)))
    else $error("count write lost"); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag0 && !(reg_wr && reg_addr == 3'd3 && reg_wdata[0])) |=> flag0)
    else $error("flag dropped without clear"); // R12

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg0.en && cfg0.oneshot && !cfg0.up && !cfg0.chain && cnt0 == '0 && !reg_wr)
    |=> (!cfg0.en && flag0 && cnt0 == '0))
    else $error("one-shot did not halt"); // R6

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg0.en && !cfg0.up && !(cfg0.chain && cfg1.chain) && cnt0 != '0 && !reg_wr)
    |=> (cnt0 == $past(cnt0) - W'(1)))
    else $error("down step wrong"); // R4

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg0.en && !reg_wr) |=> $stable(cnt0))
    else $error("disabled count moved"); // R3

endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cfg0      (cfg_q[0]),
  .cfg1      (cfg_q[1]),
  .cnt0      (cnt_q[0]),
  .flag0     (flag_q[0])
);

// File: tb/tb_tmr_pair.sv
`timescale 1ns/1ps
module tb_tmr_pair;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  tmr_pair #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rchk("R1 reset register", 3'(a), 32'h0);
    chk("R1 reset irq", {30'h0, irq}, 32'h0);
  endtask

  task automatic t_down_oneshot;
    wr(3'd1, 32'd3);
    rchk("R2 limit read next cycle", 3'd1, 32'd3);
    wr(3'd0, 32'h13);
    rchk("R3 down start loads limit", 3'd2, 32'd3);
    tick(1);
    rchk("R4 down step", 3'd2, 32'd2);
    tick(2);
    rchk("R4 reaches zero", 3'd2, 32'd0);
    rchk("R6 still enabled at zero", 3'd0, 32'h13);
    tick(1);
    rchk("R6 one-shot clears enable", 3'd0, 32'h12);
    rchk("R6 count holds terminal", 3'd2, 32'd0);
    rchk("R12 flag set", 3'd3, 32'd1);
    chk("R12 irq on", {30'h0, irq}, 32'h1);
    tick(3);
    rchk("R6 stays stopped", 3'd2, 32'd0);
    wr(3'd3, 32'd0);
    rchk("R12 write 0 keeps flag", 3'd3, 32'd1);
    wr(3'd3, 32'd1);
    rchk("R12 write 1 clears flag", 3'd3, 32'd0);
    chk("R12 irq off", {30'h0, irq}, 32'h0);
  endtask

  task automatic t_up_cont;
    wr(3'd5, 32'd2);
    wr(3'd4, 32'h05);
    rchk("R3 up start loads zero", 3'd6, 32'd0);
    tick(1);
    rchk("R5 up step", 3'd6, 32'd1);
    tick(1);
    rchk("R5 reaches limit", 3'd6, 32'd2);
    tick(1);
    rchk("R7 up reload zero", 3'd6, 32'd0);
    rchk("R12 flag timer1", 3'd7, 32'd1);
    chk("R12 irq masked", {30'h0, irq}, 32'h0);
    tick(1);
    rchk("R7 continues", 3'd6, 32'd1);
    wr(3'd4, 32'h0);
    wr(3'd7, 32'd1);
  endtask

  task automatic t_down_cont;
    wr(3'd1, 32'd2);
    wr(3'd0, 32'h01);
    rchk("R3 start", 3'd2, 32'd2);
    tick(3);
    rchk("R7 down reload limit", 3'd2, 32'd2);
    tick(1);
    rchk("R7 down continues", 3'd2, 32'd1);
  endtask

  task automatic t_data_force;
    wr(3'd2, 32'h145);
    rchk("R8 forced count", 3'd2, 32'h145);
    tick(1);
    rchk("R8 counts from forced", 3'd2, 32'h144);
    tick(4);
    rchk("R8 keeps counting", 3'd2, 32'h140);
    wr(3'd0, 32'h0);
    rchk("R3 last step on disable", 3'd2, 32'h13F);
    tick(3);
    rchk("R3 disabled holds", 3'd2, 32'h13F);
  endtask

  task automatic t_disabled_write;
    wr(3'd2, 32'h101);
    rchk("R8 write while disabled", 3'd2, 32'h101);
    tick(2);
    rchk("R3 holds written", 3'd2, 32'h101);
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h07);
    rchk("R9 up start overrides write", 3'd2, 32'd0);
    tick(3);
    rchk("R5 up reaches limit", 3'd2, 32'd3);
    tick(1);
    rchk("R6 up one-shot stops", 3'd0, 32'h06);
    rchk("R6 up holds limit", 3'd2, 32'd3);
    wr(3'd2, 32'h55);
    wr(3'd0, 32'h01);
    rchk("R9 down start overrides write", 3'd2, 32'd3);
    wr(3'd0, 32'h0);
    wr(3'd3, 32'd1);
  endtask

  task automatic t_chain_up;
    wr(3'd0, 32'h0E);
    wr(3'd4, 32'h0E);
    wr(3'd5, 32'd2);
    wr(3'd1, 32'd0);
    wr(3'd4, 32'h0F);
    rchk("R11 enable copied to timer0", 3'd0, 32'h0F);
    rchk("R3 chained start low", 3'd2, 32'd0);
    rchk("R3 chained start high", 3'd6, 32'd0);
    wr(3'd6, 32'd1);
    rchk("R10 low steps during high write", 3'd2, 32'd1);
    wr(3'd2, 32'hFFFFFF00);
    rchk("R8 chained low forced", 3'd2, 32'hFFFFFF00);
    rchk("R10 high unchanged", 3'd6, 32'd1);
    tick(255);
    rchk("R10 low all ones", 3'd2, 32'hFFFFFFFF);
    tick(1);
    rchk("R10 carry into high", 3'd6, 32'd2);
    rchk("R10 low wraps", 3'd2, 32'd0);
    tick(1);
    rchk("R6 chained stop timer0", 3'd0, 32'h0E);
    rchk("R6 chained stop timer1", 3'd4, 32'h0E);
    rchk("R12 chained flag", 3'd7, 32'd1);
    tick(2);
    rchk("R10 holds 64-bit terminal", 3'd6, 32'd2);
  endtask

  task automatic t_chain_down;
    wr(3'd3, 32'd1);
    wr(3'd7, 32'd1);
    wr(3'd0, 32'h0A);
    wr(3'd4, 32'h0A);
    wr(3'd5, 32'd1);
    wr(3'd1, 32'h10);
    wr(3'd0, 32'h0B);
    rchk("R11 enable copied to timer1", 3'd4, 32'h0B);
    rchk("R3 chained down load low", 3'd2, 32'h10);
    rchk("R3 chained down load high", 3'd6, 32'd1);
    tick(16);
    rchk("R10 low zero high one", 3'd2, 32'd0);
    rchk("R10 low zero not terminal", 3'd0, 32'h0B);
    tick(1);
    rchk("R10 borrow low", 3'd2, 32'hFFFFFFFF);
    rchk("R10 borrow high", 3'd6, 32'd0);
    wr(3'd4, 32'h0A);
    rchk("R11 disable copied", 3'd0, 32'h0A);
    tick(3);
    rchk("R11 pair holds", 3'd2, 32'hFFFFFFFE);
    wr(3'd4, 32'h0B);
    rchk("R3 chained restart", 3'd2, 32'h10);
    wr(3'd6, 32'd0);
    rchk("R10 low steps", 3'd2, 32'h0F);
    wr(3'd2, 32'd2);
    rchk("R10 high keeps", 3'd6, 32'd0);
    tick(2);
    rchk("R10 reaches zero", 3'd2, 32'd0);
    rchk("R10 still running", 3'd0, 32'h0B);
    tick(1);
    rchk("R6 chained down stop", 3'd0, 32'h0A);
    rchk("R12 chained down flag", 3'd3, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_down_oneshot();
    t_up_cont();
    t_down_cont();
    t_data_force();
    t_disabled_write();
    t_chain_up();
    t_chain_down();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule